// File: doc/BRIEF.md
# Multiplierless Binomial Smoothing Cascade

This block is a streaming one-dimensional FIR filter built only from adders, subtractors and sample-delay registers. Each stage combines the incoming sample with a delayed copy of its own input. A chain of N two-point smoothing stages therefore applies the order-N binomial kernel, which approximates a Gaussian without any multiplier. The per-stage gain is two, so the cascade gain is 2^N.

Every stage is chosen at elaboration time. Its kind is a two-point sum, a four-point sum (adding the sample two positions back) or a difference. It can have a pipeline register after its adder, or none. It can either widen its result by one bit or drop the least significant bit to keep the width constant. Samples arrive one per clock with a valid strobe. The filter history advances only on valid samples, and the output strobe is the input strobe delayed by the pipeline latency. All data is two's complement. Stage parameters are packed per stage, stage index i occupying bit i of each mask and bits [2i+1:2i] of the kind vector.

Top module: `binom_cascade`

## Requirements
- R1: A two-point smoothing stage (kind code 0) outputs x[n] + x[n-1]. Four such stages without normalisation give the impulse response 1, 4, 6, 4, 1 over successive valid samples.
- R2: A stage whose normalise bit is clear widens its result by one bit, so the output width is DATA_W plus the number of non-normalising stages.
- R3: A normalising stage drops the LSB of its sum. Stage numbers are counted from 1 at the input. Odd-numbered stages and every difference stage round toward minus infinity (floor of sum/2). Even-numbered smoothing stages round up (floor of (sum+1)/2).
- R4: A difference stage (kind code 2) outputs x[n] - x[n-1]. Four unnormalised smoothing stages followed by one difference stage give the impulse response 1, 3, 2, -2, -3, -1 over time.
- R5: A four-point stage (kind code 1) outputs x[n] + x[n-2]. Together with one two-point stage it gives the impulse response 1, 1, 1, 1.
- R6: Input and output samples are signed two's complement. Negative and extreme input values are filtered without wrap-around.
- R7: out_valid is in_valid delayed by 1 + (number of registered stages) cycles. out_data holds its value while out_valid is low.
- R8: Delay registers advance only on cycles with in_valid high. Cycles without a valid sample leave the filtered sequence unchanged, whatever in_data carries.
- R9: Reset clears all delay and output registers, so out_valid and out_data read 0. The first outputs after reset show the start-up transient computed with zero history.
- R10: In a cascade made only of normalising smoothing stages, every output lies between the smallest and largest value in the zero-initialised input history since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_data for this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Qualifies out_data |
| out_data | output | OUT_W | Signed filtered sample, registered |

## Verification
The bound checker watches the output strobe on every cycle. It keeps a count of samples in flight and requires that count to stay between zero and the latency. It also requires out_data to hold while out_valid is low. For all-normalising smoothing chains it keeps the result inside the range of the inputs seen so far. The kernel values themselves cannot be seen by a per-cycle property. These are the binomial, derivative and four-point shapes, the alternating rounding, the exact latency and the indifference to idle cycles. Only the bench scenarios show them: impulses, gapped impulses, extremes, a constant level and random streams run through three differently configured instances.

// File: rtl/binom_pkg.sv
`timescale 1ns/1ps
package binom_pkg;
  localparam logic [1:0] KIND_SUM2 = 2'd0;
  localparam logic [1:0] KIND_SUM4 = 2'd1;
  localparam logic [1:0] KIND_DIFF = 2'd2;

  // width of the sample entering stage idx (idx == stage count gives output width)
  function automatic int width_in(int data_w, logic [63:0] norm_mask, int idx);
    int w;
    w = data_w;
    for (int i = 0; i < idx; i++)
      if (!norm_mask[i]) w++;
    return w;
  endfunction

  // bit offset of link slice idx inside the flat interconnect bus
  function automatic int offset_of(int data_w, logic [63:0] norm_mask, int idx);
    int o;
    o = 0;
    for (int j = 0; j < idx; j++)
      o += width_in(data_w, norm_mask, j);
    return o;
  endfunction

  function automatic bit all_norm_smooth(logic [127:0] kinds, logic [63:0] norm_mask, int n);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (kinds[2*i +: 2] == KIND_DIFF) ok = 1'b0;
      if (!norm_mask[i]) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/binom_norm.sv
`timescale 1ns/1ps
module binom_norm #(
  parameter int SUM_W    = 9,
  parameter bit ROUND_UP = 1'b0
) (
  input  logic signed [SUM_W-1:0] sum_i,
  output logic signed [SUM_W-2:0] res_o
);
  logic signed [SUM_W-1:0] adj;

  // rounding bias never overflows: a smoothing sum is at most 2^W-2
  assign adj   = sum_i + SUM_W'(ROUND_UP);
  assign res_o = (SUM_W-1)'(adj >>> 1);
endmodule

// File: rtl/binom_stage.sv
`timescale 1ns/1ps
module binom_stage
  import binom_pkg::*;
#(
  parameter int         IN_W     = 8,
  parameter logic [1:0] KIND     = KIND_SUM2,
  parameter bit         NORM     = 1'b0,
  parameter bit         REGD     = 1'b1,
  parameter bit         ROUND_UP = 1'b0,
  localparam int        SUM_W    = IN_W + 1,
  localparam int        OUT_W    = NORM ? IN_W : SUM_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vin,
  input  logic signed [IN_W-1:0] din,
  output logic                   vout,
  output logic signed [OUT_W-1:0] dout
);
  logic signed [IN_W-1:0]  tap;
  logic signed [SUM_W-1:0] sum;
  logic signed [OUT_W-1:0] res;

  // sample history, advanced only by valid samples
  generate
    if (KIND == KIND_SUM4) begin : g_two_back
      logic signed [IN_W-1:0] h1, h2;
      always_ff @(posedge clk) begin
        if (rst) begin
          h1 <= '0;
          h2 <= '0;
        end else if (vin) begin
          h1 <= din;
          h2 <= h1;
        end
      end
      assign tap = h2;
    end else begin : g_one_back
      logic signed [IN_W-1:0] h1;
      always_ff @(posedge clk) begin
        if (rst)      h1 <= '0;
        else if (vin) h1 <= din;
      end
      assign tap = h1;
    end
  endgenerate

  generate
    if (KIND == KIND_DIFF) begin : g_sub
      assign sum = SUM_W'(din) - SUM_W'(tap);
    end else begin : g_add
      assign sum = SUM_W'(din) + SUM_W'(tap);
    end
  endgenerate

  generate
    if (NORM) begin : g_norm
      binom_norm #(.SUM_W(SUM_W), .ROUND_UP(ROUND_UP)) norm_i (
        .sum_i (sum),
        .res_o (res)
      );
    end else begin : g_wide
      assign res = sum;
    end
  endgenerate

  generate
    if (REGD) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          vout <= 1'b0;
          dout <= '0;
        end else begin
          vout <= vin;
          if (vin) dout <= res;
        end
      end
    end else begin : g_comb
      assign vout = vin;
      assign dout = res;
    end
  endgenerate
endmodule

// File: rtl/binom_cascade.sv
`timescale 1ns/1ps
module binom_cascade
  import binom_pkg::*;
#(
  parameter int                      DATA_W     = 8,
  parameter int                      NUM_STAGES = 5,
  parameter logic [2*NUM_STAGES-1:0] KIND_VEC   = 10'b10_00_00_00_00,
  parameter logic [NUM_STAGES-1:0]   NORM_MASK  = '0,
  parameter logic [NUM_STAGES-1:0]   REG_MASK   = '1,
  localparam int OUT_W = width_in(DATA_W, 64'(NORM_MASK), NUM_STAGES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);
  localparam int BUS_W    = offset_of(DATA_W, 64'(NORM_MASK), NUM_STAGES + 1);
  localparam int LAST_OFF = offset_of(DATA_W, 64'(NORM_MASK), NUM_STAGES);
  localparam int LAT      = 1 + $countones(REG_MASK);
  localparam bit ALL_NORM_SMOOTH =
    all_norm_smooth(128'(KIND_VEC), 64'(NORM_MASK), NUM_STAGES);

  logic [BUS_W-1:0]      link_d;
  logic [NUM_STAGES:0]   link_v;

  assign link_d[0 +: DATA_W] = in_data;
  assign link_v[0]           = in_valid;

  generate
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
      localparam int         WI  = width_in(DATA_W, 64'(NORM_MASK), g);
      localparam int         WO  = width_in(DATA_W, 64'(NORM_MASK), g + 1);
      localparam int         OI  = offset_of(DATA_W, 64'(NORM_MASK), g);
      localparam int         OO  = offset_of(DATA_W, 64'(NORM_MASK), g + 1);
      localparam logic [1:0] K   = KIND_VEC[2*g +: 2];
      // stage numbers start at 1: even-numbered smoothing stages round up
      localparam bit         RUP = (g % 2 == 1) && (K != KIND_DIFF);
      logic signed [WO-1:0]  so;

      binom_stage #(
        .IN_W     (WI),
        .KIND     (K),
        .NORM     (NORM_MASK[g]),
        .REGD     (REG_MASK[g]),
        .ROUND_UP (RUP)
      ) stage_i (
        .clk  (clk),
        .rst  (rst),
        .vin  (link_v[g]),
        .din  (link_d[OI +: WI]),
        .vout (link_v[g+1]),
        .dout (so)
      );
      assign link_d[OO +: WO] = so;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= link_v[NUM_STAGES];
      if (link_v[NUM_STAGES]) out_data <= link_d[LAST_OFF +: OUT_W];
    end
  end
endmodule

// File: rtl/binom_cascade_chk.sv
`timescale 1ns/1ps
module binom_cascade_chk #(
  parameter int DATA_W    = 8,
  parameter int OUT_W     = 13,
  parameter int LAT       = 6,
  parameter bit RANGE_CHK = 1'b0
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_data,
  input logic                     out_valid,
  input logic signed [OUT_W-1:0]  out_data
);
  int inflight;
  logic signed [DATA_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= 0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      inflight <= inflight + int'(in_valid) - int'(out_valid);
      if (in_valid && in_data < lo_q) lo_q <= in_data;
      if (in_valid && in_data > hi_q) hi_q <= in_data;
    end
  end

  // R7
  no_orphan_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> inflight > 0);

  // R7
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= LAT);

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  generate
    if (RANGE_CHK) begin : g_range
      // R10
      within_input_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data >= lo_q) && (out_data <= hi_q));
    end
  endgenerate
endmodule

bind binom_cascade binom_cascade_chk #(
  .DATA_W    (DATA_W),
  .OUT_W     (OUT_W),
  .LAT       (LAT),
  .RANGE_CHK (ALL_NORM_SMOOTH)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/binom_cascade_tb_top.sv
`timescale 1ns/1ps
module binom_cascade_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [7:0] in_data = '0;

  logic ov0, ov1, ov2;
  logic signed [12:0] od0;
  logic signed [7:0]  od1;
  logic signed [9:0]  od2;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // 4 x two-point + difference, all registered, full width (latency 6)
  binom_cascade dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov0), .out_data(od0));

  // 4 normalising two-point stages, stages 1 and 3 registered (latency 3)
  binom_cascade #(.DATA_W(8), .NUM_STAGES(4), .KIND_VEC(8'h00),
                  .NORM_MASK(4'b1111), .REG_MASK(4'b0101)) dut_nrm_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov1), .out_data(od1));

  // four-point then two-point, unregistered (latency 1)
  binom_cascade #(.DATA_W(8), .NUM_STAGES(2), .KIND_VEC(4'b00_01),
                  .NORM_MASK(2'b00), .REG_MASK(2'b00)) dut_q_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov2), .out_data(od2));

  // ---------------- reference model from the requirements ----------------
  int mk [3][5];
  int mn [3][5];
  int ns [3];
  int lat [3];
  int h1 [3][5];
  int h2 [3][5];
  int q0[$], q1[$], q2[$];
  int s0[$], s1[$], s2[$];
  int g0[$], g1[$], g2[$];

  function automatic int model_step(int c, int xin);
    int x, tap, sum, r;
    x = xin;
    for (int s = 0; s < ns[c]; s++) begin
      tap = (mk[c][s] == 1) ? h2[c][s] : h1[c][s];
      sum = (mk[c][s] == 2) ? x - tap : x + tap;
      h2[c][s] = h1[c][s];
      h1[c][s] = x;
      if (mn[c][s] != 0) begin
        if (mk[c][s] != 2 && (s % 2 == 1)) r = (sum + 1) >>> 1;
        else                               r = sum >>> 1;
      end else r = sum;
      x = r;
    end
    return x;
  endfunction

  task automatic note(input bit ok, input string req, input int got, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic take(input int c, input int got);
    int e, st;
    bit empty;
    empty = 1'b0;
    if (c == 0) begin if (q0.size() == 0) empty = 1'b1; else begin e = q0.pop_front(); st = s0.pop_front(); g0.push_back(got); end end
    else if (c == 1) begin if (q1.size() == 0) empty = 1'b1; else begin e = q1.pop_front(); st = s1.pop_front(); g1.push_back(got); end end
    else begin if (q2.size() == 0) empty = 1'b1; else begin e = q2.pop_front(); st = s2.pop_front(); g2.push_back(got); end end
    if (empty) begin
      note(1'b0, "R7 unexpected out_valid", got, 0);
    end else begin
      // R1 R3 R4 R5 R6 R8 R9: streaming value against the model
      note(got == e, "R1/R3/R4/R5/R6/R8 sample value", got, e);
      // R7: latency in cycles
      note(cyc - st == lat[c], "R7 latency", cyc - st, lat[c]);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (ov0) take(0, int'(od0));
      if (ov1) take(1, int'(od1));
      if (ov2) take(2, int'(od2));
    end
  end

  task automatic send(input bit v, input int x);
    @(negedge clk);
    in_valid = v;
    in_data  = 8'(x);
    if (v) begin
      q0.push_back(model_step(0, x)); s0.push_back(cyc);
      q1.push_back(model_step(1, x)); s1.push_back(cyc);
      q2.push_back(model_step(2, x)); s2.push_back(cyc);
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 10; i++) send(1'b0, 0);
  endtask

  task automatic kernel_chk(input int c, input int base, input int exp[], input string req);
    int got;
    for (int i = 0; i < exp.size(); i++) begin
      got = (c == 0) ? g0[base+i] : (c == 1) ? g1[base+i] : g2[base+i];
      note(got == exp[i], req, got, exp[i]);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int b0, b1, b2;
    void'($urandom(32'd20240611));
    ns = '{5, 4, 2};
    lat = '{6, 3, 1};
    mk = '{'{0,0,0,0,2}, '{0,0,0,0,0}, '{1,0,0,0,0}};
    mn = '{'{0,0,0,0,0}, '{1,1,1,1,0}, '{0,0,0,0,0}};
    foreach (h1[i, j]) begin h1[i][j] = 0; h2[i][j] = 0; end

    repeat (4) @(negedge clk);
    // R9: reset state
    note(ov0 == 1'b0 && od0 == 0, "R9 reset dut_i", int'(od0), 0);
    note(ov1 == 1'b0 && od1 == 0, "R9 reset dut_nrm_i", int'(od1), 0);
    note(ov2 == 1'b0 && od2 == 0, "R9 reset dut_q_i", int'(od2), 0);
    rst = 1'b0;

    // R2: output widths
    note($bits(od0) == 13, "R2 width dut_i", $bits(od0), 13);
    note($bits(od1) == 8,  "R2 width dut_nrm_i", $bits(od1), 8);
    note($bits(od2) == 10, "R2 width dut_q_i", $bits(od2), 10);

    // R1 R4 R5 R9: impulse from zero history
    send(1'b1, 16);
    for (int i = 0; i < 8; i++) send(1'b1, 0);
    flush();
    kernel_chk(0, 0, '{16, 48, 32, -32, -48, -16, 0}, "R4 derivative kernel");
    kernel_chk(1, 0, '{1, 4, 6, 4, 1, 0}, "R1 binomial kernel normalised");
    kernel_chk(2, 0, '{16, 16, 16, 16, 0}, "R5 four-point kernel");

    // R8: same impulse with idle cycles carrying junk in between
    b0 = g0.size(); b1 = g1.size(); b2 = g2.size();
    send(1'b1, 16);
    for (int i = 0; i < 8; i++) begin
      send(1'b0, 99 - 7*i);
      send(1'b0, -100);
      send(1'b1, 0);
    end
    flush();
    kernel_chk(0, b0, '{16, 48, 32, -32, -48, -16, 0}, "R8 gapped derivative kernel");
    kernel_chk(1, b1, '{1, 4, 6, 4, 1, 0}, "R8 gapped binomial kernel");
    kernel_chk(2, b2, '{16, 16, 16, 16, 0}, "R8 gapped four-point kernel");

    // R3: short step exposes alternating rounding: out 0,0,1,1,0,0
    b1 = g1.size();
    send(1'b1, 1); send(1'b1, 1);
    for (int i = 0; i < 4; i++) send(1'b1, 0);
    flush();
    kernel_chk(1, b1, '{0, 0, 1, 1, 0, 0}, "R3 rounding pattern");

    // R6: extremes
    for (int i = 0; i < 12; i++) send(1'b1, 127);
    for (int i = 0; i < 12; i++) send(1'b1, -128);
    for (int i = 0; i < 6; i++)  send(1'b1, (i % 2) ? 127 : -128);

    // R3: constant level settles to itself
    for (int i = 0; i < 20; i++) send(1'b1, 5);
    flush();
    note(g1[g1.size()-1] == 5, "R3 DC level", g1[g1.size()-1], 5);

    // random stream with random gaps
    for (int i = 0; i < 400; i++) begin
      send(($urandom % 4) != 0, int'($signed(8'($urandom))));
    end
    flush();

    // R7: every pushed sample came out
    note(q0.size() == 0, "R7 drained dut_i", q0.size(), 0);
    note(q1.size() == 0, "R7 drained dut_nrm_i", q1.size(), 0);
    note(q2.size() == 0, "R7 drained dut_q_i", q2.size(), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule